// File: doc/BRIEF.md
# Multithreaded Fetch PC Sequencer

This block owns the next fetch address of every hardware thread in an in-order pipeline. For each thread it holds a program counter, a flag saying whether that counter can be trusted, a running instruction sequence counter and the index of the pipeline stage that was last held up waiting on it. Pipeline stages send one request per cycle, tagged with a thread. An assign request takes the current address and a fresh sequence number. A target-update request looks at a control instruction. It either stalls the pipeline until a return address is resolved, or raises a redirect for a predicted-taken branch.

Redirect notices come in on several parallel ports in the same cycle. Within that cycle, older instructions override younger ones, and a notice that is not older than one already accepted for the same thread is dropped. An accepted redirect loads the branch target, or the address after a non-branch instruction. If the instruction just behind the branch already sits at the target, it skips one more instruction. A stage that was held up is then told to resume. A redirect from a faulting instruction leaves the thread waiting for a trap. Trap, activate and deactivate inputs reload or clear a thread directly.

Top module: `fetch_pc_seq`

## Requirements
- R1: After reset or a deactivate pulse, a thread's address is invalid and its recorded held-stage index is 0. A later redirect that unblocks it reports stage 0.
- R2: An assign request (req_kind = 0) on a valid thread completes in the same cycle. It returns the thread's address and sequence count, and the next cycle holds address + 4 and count + 1.
- R3: An assign request on an invalid thread does not complete and changes nothing.
- R4: A request flagged as faulting completes at once. It raises no hold and no redirect, and leaves address and count unchanged.
- R5: A target-update request (req_kind = 1) for a return that was not predicted taken completes, asserts the hold output, invalidates the thread and records the requesting stage.
- R6: A target-update for a predicted-taken control instruction raises a redirect carrying the requesting stage and the request's sequence number. A target-update for a non-control instruction completes with no other effect.
- R7: Redirect ports are taken in index order within a cycle. A port for a thread that already has an accepted redirect this cycle is dropped unless its sequence number is strictly smaller. Redirects for different threads are independent.
- R8: An accepted redirect marked faulting leaves the thread invalid.
- R9: An accepted non-fault redirect loads the predicted target for a control instruction, or target + 4 when the next instruction is present at exactly the target. For a non-control instruction it loads the instruction address + 4.
- R10: A non-fault redirect to an invalid thread pulses that thread's unblock output with the recorded stage, and leaves the thread valid. A redirect to a valid thread gives no pulse.
- R11: A trap or activate pulse loads the thread's address from its architectural address input and makes it valid.
- R12: A request to a thread that receives an accepted redirect in the same cycle does not complete and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_kind | input | 1 | 0 = assign, 1 = target update |
| req_tid | input | TID_W | Requesting thread |
| req_stage | input | STG_W | Requesting stage index |
| req_fault | input | 1 | Instruction already carries a fault |
| req_ctrl | input | 1 | Instruction is a control transfer |
| req_ret | input | 1 | Instruction is a return |
| req_pred | input | 1 | Instruction predicted taken |
| req_seq | input | 32 | Sequence number of the instruction |
| req_done | output | 1 | Request completed this cycle |
| rsp_pc | output | 32 | Assigned fetch address |
| rsp_seq | output | 32 | Assigned sequence number |
| blk_valid | output | 1 | Hold the requesting stage |
| sqo_valid | output | 1 | Redirect raised |
| sqo_stage | output | STG_W | Stage the redirect starts from |
| sqo_seq | output | 32 | Sequence number tagging the redirect |
| sq_valid | input | NSQ | Redirect notice per port |
| sq_tid | input | NSQ x TID_W | Thread per port |
| sq_seq | input | NSQ x 32 | Sequence number of the causing instruction |
| sq_fault | input | NSQ | Causing instruction faulted |
| sq_ctrl | input | NSQ | Causing instruction is a control transfer |
| sq_pc | input | NSQ x 32 | Address of the causing instruction |
| sq_tgt | input | NSQ x 32 | Predicted target |
| sq_slot_v | input | NSQ | Next younger instruction present |
| sq_slot_pc | input | NSQ x 32 | Address of that younger instruction |
| ub_valid | output | THREADS | Unblock pulse per thread |
| ub_stage | output | THREADS x STG_W | Stage to unblock per thread |
| trap_vec | input | THREADS | Trap reload per thread |
| act_vec | input | THREADS | Activate per thread |
| deact_vec | input | THREADS | Deactivate per thread |
| arch_pc | input | THREADS x 32 | Architectural address per thread |

## Verification
The hardest case to reach from the ports is two redirect notices for the same thread arriving together on different ports. Whether the second one wins depends only on how the two sequence numbers compare. The stimulus drives both ports in one cycle with equal numbers, then with a strictly older number on the later port, then with different threads. Each time, the winning address is read back through the next assign request. The unblock pulse is also hard to reach. Its stage comes from state written earlier, by a held return or by a deactivate. The bench first parks a thread in the held state, and only then redirects it.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;
  localparam int unsigned PC_W  = 32;
  localparam int unsigned SEQ_W = 32;
  localparam logic [PC_W-1:0] INSN_BYTES = 32'd4;

  typedef enum logic {
    REQ_ASSIGN = 1'b0,
    REQ_TARGET = 1'b1
  } req_kind_e;

  function automatic logic [PC_W-1:0] pc_step(input logic [PC_W-1:0] pc);
    return pc + INSN_BYTES;
  endfunction

  function automatic logic [PC_W-1:0] redirect_pc(
    input logic            is_ctrl,
    input logic [PC_W-1:0] insn_pc,
    input logic [PC_W-1:0] tgt,
    input logic            slot_v,
    input logic [PC_W-1:0] slot_pc
  );
    if (!is_ctrl)                  return pc_step(insn_pc);
    if (slot_v && (slot_pc == tgt)) return pc_step(tgt);
    return tgt;
  endfunction

  function automatic logic younger_or_same(
    input logic [SEQ_W-1:0] held,
    input logic [SEQ_W-1:0] incoming
  );
    return held <= incoming;
  endfunction
endpackage

// File: rtl/pcseq_squash_chain.sv
module pcseq_squash_chain
  import pcseq_pkg::*;
#(
  parameter int unsigned NSQ   = 2,
  parameter int unsigned TID_W = 1,
  parameter int unsigned TID   = 0
) (
  input  logic [NSQ-1:0]             sq_valid,
  input  logic [NSQ-1:0][TID_W-1:0]  sq_tid,
  input  logic [NSQ-1:0][SEQ_W-1:0]  sq_seq,
  input  logic [NSQ-1:0]             sq_fault,
  input  logic [NSQ-1:0]             sq_ctrl,
  input  logic [NSQ-1:0][PC_W-1:0]   sq_pc,
  input  logic [NSQ-1:0][PC_W-1:0]   sq_tgt,
  input  logic [NSQ-1:0]             sq_slot_v,
  input  logic [NSQ-1:0][PC_W-1:0]   sq_slot_pc,
  input  logic                       vld_in,
  input  logic [PC_W-1:0]            pc_in,
  output logic                       hit,
  output logic                       pc_wr,
  output logic [PC_W-1:0]            pc_out,
  output logic                       vld_out,
  output logic                       unblock
);
  always_comb begin
    logic             taken;
    logic [SEQ_W-1:0] rec;
    logic             v;
    logic [PC_W-1:0]  p;
    logic             w;
    logic             u;
    taken = 1'b0;
    rec   = '1;
    v     = vld_in;
    p     = pc_in;
    w     = 1'b0;
    u     = 1'b0;
    for (int k = 0; k < NSQ; k++) begin
      if (sq_valid[k] && (sq_tid[k] == TID_W'(TID))) begin
        if (!(taken && younger_or_same(rec, sq_seq[k]))) begin
          taken = 1'b1;
          rec   = sq_seq[k];
          if (sq_fault[k]) begin
            v = 1'b0;
          end else begin
            p = redirect_pc(sq_ctrl[k], sq_pc[k], sq_tgt[k], sq_slot_v[k], sq_slot_pc[k]);
            w = 1'b1;
            if (!v) u = 1'b1;
            v = 1'b1;
          end
        end
      end
    end
    hit     = taken;
    pc_wr   = w;
    pc_out  = p;
    vld_out = v;
    unblock = u & v;
  end
endmodule

// File: rtl/pcseq_thread.sv
module pcseq_thread
  import pcseq_pkg::*;
#(
  parameter int unsigned NSQ   = 2,
  parameter int unsigned TID_W = 1,
  parameter int unsigned STG_W = 3,
  parameter int unsigned TID   = 0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_hit,
  input  logic                       req_kind,
  input  logic                       req_fault,
  input  logic                       req_ctrl,
  input  logic                       req_ret,
  input  logic                       req_pred,
  input  logic [STG_W-1:0]           req_stage,
  input  logic [NSQ-1:0]             sq_valid,
  input  logic [NSQ-1:0][TID_W-1:0]  sq_tid,
  input  logic [NSQ-1:0][SEQ_W-1:0]  sq_seq,
  input  logic [NSQ-1:0]             sq_fault,
  input  logic [NSQ-1:0]             sq_ctrl,
  input  logic [NSQ-1:0][PC_W-1:0]   sq_pc,
  input  logic [NSQ-1:0][PC_W-1:0]   sq_tgt,
  input  logic [NSQ-1:0]             sq_slot_v,
  input  logic [NSQ-1:0][PC_W-1:0]   sq_slot_pc,
  input  logic                       load,
  input  logic [PC_W-1:0]            load_pc,
  input  logic                       deact,
  output logic                       done,
  output logic                       blk,
  output logic                       sqo,
  output logic                       ub,
  output logic [STG_W-1:0]           ub_stg,
  output logic                       vld_o,
  output logic [PC_W-1:0]            pc_o,
  output logic [SEQ_W-1:0]           seq_o
);
  logic             vld_q, vld_d;
  logic [PC_W-1:0]  pc_q, pc_d;
  logic [SEQ_W-1:0] seq_q, seq_d;
  logic [STG_W-1:0] stg_q, stg_d;

  logic             sq_hit, sq_pc_wr, sq_vld;
  logic [PC_W-1:0]  sq_pc_new;

  pcseq_squash_chain #(.NSQ(NSQ), .TID_W(TID_W), .TID(TID)) u_chain (
    .sq_valid  (sq_valid),
    .sq_tid    (sq_tid),
    .sq_seq    (sq_seq),
    .sq_fault  (sq_fault),
    .sq_ctrl   (sq_ctrl),
    .sq_pc     (sq_pc),
    .sq_tgt    (sq_tgt),
    .sq_slot_v (sq_slot_v),
    .sq_slot_pc(sq_slot_pc),
    .vld_in    (vld_q),
    .pc_in     (pc_q),
    .hit       (sq_hit),
    .pc_wr     (sq_pc_wr),
    .pc_out    (sq_pc_new),
    .vld_out   (sq_vld),
    .unblock   (ub)
  );

  always_comb begin
    pc_d  = pc_q;
    vld_d = vld_q;
    stg_d = stg_q;
    seq_d = seq_q;
    done  = 1'b0;
    blk   = 1'b0;
    sqo   = 1'b0;
    if (req_hit && !sq_hit) begin
      if (req_fault) begin
        done = 1'b1;
      end else if (req_kind == REQ_ASSIGN) begin
        if (vld_q) begin
          done  = 1'b1;
          pc_d  = pc_step(pc_q);
          seq_d = seq_q + SEQ_W'(1);
        end
      end else begin
        done = 1'b1;
        if (req_ctrl) begin
          if (req_ret && !req_pred) begin
            blk   = 1'b1;
            vld_d = 1'b0;
            stg_d = req_stage;
          end else if (req_pred) begin
            sqo = 1'b1;
          end
        end
      end
    end
    if (sq_hit) begin
      if (sq_pc_wr) pc_d = sq_pc_new;
      vld_d = sq_vld;
    end
    if (load) begin
      pc_d  = load_pc;
      vld_d = 1'b1;
    end
    if (deact) begin
      vld_d = 1'b0;
      stg_d = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      pc_q  <= '0;
      seq_q <= '0;
      stg_q <= '0;
    end else begin
      vld_q <= vld_d;
      pc_q  <= pc_d;
      seq_q <= seq_d;
      stg_q <= stg_d;
    end
  end

  assign ub_stg = stg_q;
  assign vld_o  = vld_q;
  assign pc_o   = pc_q;
  assign seq_o  = seq_q;
endmodule

// File: rtl/fetch_pc_seq.sv
module fetch_pc_seq
  import pcseq_pkg::*;
#(
  parameter int unsigned THREADS = 2,
  parameter int unsigned NSQ     = 2,
  parameter int unsigned STG_W   = 3,
  localparam int unsigned TID_W  = (THREADS > 1) ? $clog2(THREADS) : 1
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            req_valid,
  input  logic                            req_kind,
  input  logic [TID_W-1:0]                req_tid,
  input  logic [STG_W-1:0]                req_stage,
  input  logic                            req_fault,
  input  logic                            req_ctrl,
  input  logic                            req_ret,
  input  logic                            req_pred,
  input  logic [31:0]                     req_seq,
  output logic                            req_done,
  output logic [31:0]                     rsp_pc,
  output logic [31:0]                     rsp_seq,
  output logic                            blk_valid,
  output logic                            sqo_valid,
  output logic [STG_W-1:0]                sqo_stage,
  output logic [31:0]                     sqo_seq,
  input  logic [NSQ-1:0]                  sq_valid,
  input  logic [NSQ-1:0][TID_W-1:0]       sq_tid,
  input  logic [NSQ-1:0][31:0]            sq_seq,
  input  logic [NSQ-1:0]                  sq_fault,
  input  logic [NSQ-1:0]                  sq_ctrl,
  input  logic [NSQ-1:0][31:0]            sq_pc,
  input  logic [NSQ-1:0][31:0]            sq_tgt,
  input  logic [NSQ-1:0]                  sq_slot_v,
  input  logic [NSQ-1:0][31:0]            sq_slot_pc,
  output logic [THREADS-1:0]              ub_valid,
  output logic [THREADS-1:0][STG_W-1:0]   ub_stage,
  input  logic [THREADS-1:0]              trap_vec,
  input  logic [THREADS-1:0]              act_vec,
  input  logic [THREADS-1:0]              deact_vec,
  input  logic [THREADS-1:0][31:0]        arch_pc
);
  logic [THREADS-1:0]             done_v, blk_v, sqo_v, vld_vec;
  logic [THREADS-1:0][PC_W-1:0]   pc_vec;
  logic [THREADS-1:0][SEQ_W-1:0]  seq_vec;

  for (genvar t = 0; t < THREADS; t++) begin : g_thr
    pcseq_thread #(.NSQ(NSQ), .TID_W(TID_W), .STG_W(STG_W), .TID(t)) u_thr (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_hit   (req_valid && (req_tid == TID_W'(t))),
      .req_kind  (req_kind),
      .req_fault (req_fault),
      .req_ctrl  (req_ctrl),
      .req_ret   (req_ret),
      .req_pred  (req_pred),
      .req_stage (req_stage),
      .sq_valid  (sq_valid),
      .sq_tid    (sq_tid),
      .sq_seq    (sq_seq),
      .sq_fault  (sq_fault),
      .sq_ctrl   (sq_ctrl),
      .sq_pc     (sq_pc),
      .sq_tgt    (sq_tgt),
      .sq_slot_v (sq_slot_v),
      .sq_slot_pc(sq_slot_pc),
      .load      (trap_vec[t] | act_vec[t]),
      .load_pc   (arch_pc[t]),
      .deact     (deact_vec[t]),
      .done      (done_v[t]),
      .blk       (blk_v[t]),
      .sqo       (sqo_v[t]),
      .ub        (ub_valid[t]),
      .ub_stg    (ub_stage[t]),
      .vld_o     (vld_vec[t]),
      .pc_o      (pc_vec[t]),
      .seq_o     (seq_vec[t])
    );
  end

  always_comb begin
    req_done  = 1'b0;
    rsp_pc    = '0;
    rsp_seq   = '0;
    blk_valid = 1'b0;
    sqo_valid = 1'b0;
    for (int t = 0; t < THREADS; t++) begin
      if (req_tid == TID_W'(t)) begin
        req_done  = done_v[t];
        rsp_pc    = pc_vec[t];
        rsp_seq   = seq_vec[t];
        blk_valid = blk_v[t];
        sqo_valid = sqo_v[t];
      end
    end
  end

  assign sqo_stage = sqo_valid ? req_stage : '0;
  assign sqo_seq   = sqo_valid ? req_seq   : '0;
endmodule

// File: rtl/pcseq_checker.sv
module pcseq_checker #(
  parameter int unsigned THREADS = 2,
  parameter int unsigned TID_W   = 1
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      req_valid,
  input logic                      req_kind,
  input logic [TID_W-1:0]          req_tid,
  input logic                      req_fault,
  input logic                      req_done,
  input logic [31:0]               rsp_pc,
  input logic [31:0]               rsp_seq,
  input logic                      blk_valid,
  input logic                      sqo_valid,
  input logic [THREADS-1:0]        ub_valid,
  input logic [THREADS-1:0]        trap_vec,
  input logic [THREADS-1:0]        act_vec,
  input logic [THREADS-1:0]        deact_vec,
  input logic [THREADS-1:0][31:0]  arch_pc,
  input logic [THREADS-1:0]        vld_vec,
  input logic [THREADS-1:0][31:0]  pc_vec,
  input logic [THREADS-1:0][31:0]  seq_vec
);
  // R6
  sqo_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sqo_valid |-> (req_valid && req_done && req_kind));

  for (genvar t = 0; t < THREADS; t++) begin : g_chk
    logic sel;
    logic ld;
    assign sel = req_valid && (req_tid == TID_W'(t));
    assign ld  = trap_vec[t] | act_vec[t];

    // R2
    assign_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && !req_kind && !req_fault && req_done && !ld && !deact_vec[t])
      |=> (pc_vec[t] == $past(rsp_pc) + 32'd4) && (seq_vec[t] == $past(rsp_seq) + 32'd1));

    // R3
    invalid_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && !req_kind && !req_fault && !vld_vec[t]) |-> !req_done);

    // R5
    hold_clears_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && blk_valid && !ld) |=> !vld_vec[t]);

    // R10
    unblock_from_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ub_valid[t] |-> !vld_vec[t]);

    // R10
    unblock_sets_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ub_valid[t] && !deact_vec[t]) |=> vld_vec[t]);

    // R1
    deact_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      deact_vec[t] |=> !vld_vec[t]);

    // R11
    load_sets_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ld && !deact_vec[t]) |=> (vld_vec[t] && (pc_vec[t] == $past(arch_pc[t]))));
  end
endmodule

bind fetch_pc_seq pcseq_checker #(.THREADS(THREADS), .TID_W(TID_W)) u_pcseq_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_kind (req_kind),
  .req_tid  (req_tid),
  .req_fault(req_fault),
  .req_done (req_done),
  .rsp_pc   (rsp_pc),
  .rsp_seq  (rsp_seq),
  .blk_valid(blk_valid),
  .sqo_valid(sqo_valid),
  .ub_valid (ub_valid),
  .trap_vec (trap_vec),
  .act_vec  (act_vec),
  .deact_vec(deact_vec),
  .arch_pc  (arch_pc),
  .vld_vec  (vld_vec),
  .pc_vec   (pc_vec),
  .seq_vec  (seq_vec)
);

// File: tb/test_fetch_pc_seq.sv
module test_fetch_pc_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic             req_valid, req_kind, req_tid, req_fault, req_ctrl, req_ret, req_pred;
  logic [2:0]       req_stage;
  logic [31:0]      req_seq;
  logic             req_done, blk_valid, sqo_valid;
  logic [31:0]      rsp_pc, rsp_seq, sqo_seq;
  logic [2:0]       sqo_stage;
  logic [1:0]       sq_valid, sq_tid, sq_fault, sq_ctrl, sq_slot_v;
  logic [1:0][31:0] sq_seq, sq_pc, sq_tgt, sq_slot_pc;
  logic [1:0]       ub_valid;
  logic [1:0][2:0]  ub_stage;
  logic [1:0]       trap_vec, act_vec, deact_vec;
  logic [1:0][31:0] arch_pc;

  fetch_pc_seq i_fetch_pc_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_kind(req_kind), .req_tid(req_tid), .req_stage(req_stage),
    .req_fault(req_fault), .req_ctrl(req_ctrl), .req_ret(req_ret), .req_pred(req_pred),
    .req_seq(req_seq), .req_done(req_done), .rsp_pc(rsp_pc), .rsp_seq(rsp_seq),
    .blk_valid(blk_valid), .sqo_valid(sqo_valid), .sqo_stage(sqo_stage), .sqo_seq(sqo_seq),
    .sq_valid(sq_valid), .sq_tid(sq_tid), .sq_seq(sq_seq), .sq_fault(sq_fault),
    .sq_ctrl(sq_ctrl), .sq_pc(sq_pc), .sq_tgt(sq_tgt), .sq_slot_v(sq_slot_v),
    .sq_slot_pc(sq_slot_pc), .ub_valid(ub_valid), .ub_stage(ub_stage),
    .trap_vec(trap_vec), .act_vec(act_vec), .deact_vec(deact_vec), .arch_pc(arch_pc)
  );

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clear_in();
    req_valid = 0; req_kind = 0; req_tid = 0; req_fault = 0; req_ctrl = 0;
    req_ret = 0; req_pred = 0; req_stage = 0; req_seq = 0;
    sq_valid = 0; sq_tid = 0; sq_fault = 0; sq_ctrl = 0; sq_slot_v = 0;
    sq_seq = '0; sq_pc = '0; sq_tgt = '0; sq_slot_pc = '0;
    trap_vec = 0; act_vec = 0; deact_vec = 0; arch_pc = '0;
  endtask

  task automatic next_cycle();
    @(negedge clk);
    clear_in();
  endtask

  task automatic put_sq(input int k, input logic tid, input logic [31:0] seq, input logic flt,
                        input logic ctl, input logic [31:0] pc, input logic [31:0] tgt,
                        input logic sv, input logic [31:0] spc);
    sq_valid[k] = 1'b1; sq_tid[k] = tid; sq_seq[k] = seq; sq_fault[k] = flt;
    sq_ctrl[k] = ctl; sq_pc[k] = pc; sq_tgt[k] = tgt; sq_slot_v[k] = sv; sq_slot_pc[k] = spc;
  endtask

  // assign request on a thread, then checks outcome and steps a cycle
  task automatic do_assign(input string req, input logic tid, input logic exp_done,
                           input logic [31:0] exp_pc, input logic [31:0] exp_seq);
    req_valid = 1; req_kind = 0; req_tid = tid;
    #2;
    check(req, {31'd0, req_done}, {31'd0, exp_done});
    if (exp_done) begin
      check(req, rsp_pc, exp_pc);
      check(req, rsp_seq, exp_seq);
    end
    next_cycle();
  endtask

  typedef struct packed {
    logic       kind;
    logic       tid;
    logic       fault;
    logic       ctrl;
    logic       ret;
    logic       pred;
    logic [2:0] stg;
    logic [7:0] rseq;
    logic       e_done;
    logic       e_blk;
    logic       e_sqo;
    logic [31:0] e_pc;
    logic [7:0] e_seq;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd1, 8'd0, 1'b1, 1'b0, 1'b0, 32'h1000, 8'd0}, // R2
    '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 3'd1, 8'd0, 1'b1, 1'b0, 1'b0, 32'h2000, 8'd0}, // R2
    '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd1, 8'd0, 1'b1, 1'b0, 1'b0, 32'h1004, 8'd1}, // R2
    '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd1, 8'd0, 1'b1, 1'b0, 1'b0, 32'h0,    8'd0}, // R6 non-control
    '{1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 3'd3, 8'd5, 1'b1, 1'b0, 1'b1, 32'h0,    8'd0}, // R6 taken
    '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 3'd1, 8'd0, 1'b1, 1'b0, 1'b0, 32'h0,    8'd0}, // R4
    '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd1, 8'd0, 1'b1, 1'b0, 1'b0, 32'h1008, 8'd2}, // R4 unchanged
    '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 3'd2, 8'd0, 1'b1, 1'b1, 1'b0, 32'h0,    8'd0}, // R5
    '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 3'd1, 8'd0, 1'b0, 1'b0, 1'b0, 32'h0,    8'd0}, // R3
    '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd1, 8'd0, 1'b1, 1'b0, 1'b0, 32'h100C, 8'd3}, // R2
    '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 3'd4, 8'd9, 1'b1, 1'b0, 1'b1, 32'h0,    8'd0}, // R6 return taken
    '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 3'd1, 8'd0, 1'b0, 1'b0, 1'b0, 32'h0,    8'd0}  // R3
  };

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin : main
    clear_in();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: nothing valid after reset
    do_assign("R1 reset stall", 1'b0, 1'b0, 32'h0, 32'h0);

    act_vec = 2'b11; arch_pc[0] = 32'h1000; arch_pc[1] = 32'h2000;
    next_cycle();

    for (int i = 0; i < NV; i++) begin
      req_valid = 1; req_kind = VECS[i].kind; req_tid = VECS[i].tid;
      req_fault = VECS[i].fault; req_ctrl = VECS[i].ctrl; req_ret = VECS[i].ret;
      req_pred = VECS[i].pred; req_stage = VECS[i].stg; req_seq = {24'd0, VECS[i].rseq};
      #2;
      check($sformatf("R2-table vector %0d done", i), {31'd0, req_done}, {31'd0, VECS[i].e_done});
      check($sformatf("R5 vector %0d hold", i), {31'd0, blk_valid}, {31'd0, VECS[i].e_blk});
      check($sformatf("R6 vector %0d redirect", i), {31'd0, sqo_valid}, {31'd0, VECS[i].e_sqo});
      if (VECS[i].e_sqo) begin
        check("R6 redirect stage", {29'd0, sqo_stage}, {29'd0, VECS[i].stg});
        check("R6 redirect seq", sqo_seq, {24'd0, VECS[i].rseq});
      end
      if (VECS[i].e_done && !VECS[i].kind && !VECS[i].fault) begin
        check($sformatf("R2 vector %0d pc", i), rsp_pc, VECS[i].e_pc);
        check($sformatf("R2 vector %0d seq", i), rsp_seq, {24'd0, VECS[i].e_seq});
      end
      next_cycle();
    end

    // R10 + R9: thread 1 held at stage 2, non-control redirect at 0x3000
    put_sq(0, 1'b1, 32'd20, 1'b0, 1'b0, 32'h3000, 32'h0, 1'b0, 32'h0);
    #2;
    check("R10 unblock pulse", {31'd0, ub_valid[1]}, 32'd1);
    check("R10 unblock stage", {29'd0, ub_stage[1]}, 32'd2);
    next_cycle();
    do_assign("R9 non-control fallthrough", 1'b1, 1'b1, 32'h3004, 32'd1);

    // R12 + R9 delay-slot skip + R10 no pulse when valid
    put_sq(0, 1'b0, 32'd30, 1'b0, 1'b1, 32'h0, 32'h4000, 1'b1, 32'h4000);
    req_valid = 1; req_kind = 0; req_tid = 0;
    #2;
    check("R12 request killed", {31'd0, req_done}, 32'd0);
    check("R10 no pulse on valid", {31'd0, ub_valid[0]}, 32'd0);
    next_cycle();
    do_assign("R9 slot skip", 1'b0, 1'b1, 32'h4004, 32'd4);

    // R9: slot present elsewhere -> plain target
    put_sq(0, 1'b0, 32'd31, 1'b0, 1'b1, 32'h0, 32'h5000, 1'b1, 32'h5008);
    next_cycle();
    do_assign("R9 target", 1'b0, 1'b1, 32'h5000, 32'd5);

    // R7: equal seq on later port dropped
    put_sq(0, 1'b0, 32'd10, 1'b0, 1'b1, 32'h0, 32'h6000, 1'b0, 32'h0);
    put_sq(1, 1'b0, 32'd10, 1'b0, 1'b1, 32'h0, 32'h7000, 1'b0, 32'h0);
    next_cycle();
    do_assign("R7 equal dropped", 1'b0, 1'b1, 32'h6000, 32'd6);

    // R7: strictly older on later port wins
    put_sq(0, 1'b0, 32'd10, 1'b0, 1'b1, 32'h0, 32'h6000, 1'b0, 32'h0);
    put_sq(1, 1'b0, 32'd9,  1'b0, 1'b1, 32'h0, 32'h7000, 1'b0, 32'h0);
    next_cycle();
    do_assign("R7 older wins", 1'b0, 1'b1, 32'h7000, 32'd7);

    // R7: different threads independent
    put_sq(0, 1'b0, 32'd5, 1'b0, 1'b1, 32'h0, 32'h9000, 1'b0, 32'h0);
    put_sq(1, 1'b1, 32'd9, 1'b0, 1'b1, 32'h0, 32'hA000, 1'b0, 32'h0);
    next_cycle();
    do_assign("R7 thread0", 1'b0, 1'b1, 32'h9000, 32'd8);
    do_assign("R7 thread1", 1'b1, 1'b1, 32'hA000, 32'd2);

    // R8: faulting redirect leaves thread invalid
    put_sq(0, 1'b0, 32'd40, 1'b1, 1'b0, 32'h0, 32'h0, 1'b0, 32'h0);
    next_cycle();
    do_assign("R8 fault redirect", 1'b0, 1'b0, 32'h0, 32'h0);

    // R11: trap reload
    trap_vec[0] = 1'b1; arch_pc[0] = 32'h8000;
    next_cycle();
    do_assign("R11 trap reload", 1'b0, 1'b1, 32'h8000, 32'd9);

    // R1: deactivate clears validity and held-stage index
    deact_vec[1] = 1'b1;
    next_cycle();
    do_assign("R1 deactivate stall", 1'b1, 1'b0, 32'h0, 32'h0);
    put_sq(0, 1'b1, 32'd50, 1'b0, 1'b0, 32'h100, 32'h0, 1'b0, 32'h0);
    #2;
    check("R1 unblock pulse", {31'd0, ub_valid[1]}, 32'd1);
    check("R1 stage cleared", {29'd0, ub_stage[1]}, 32'd0);
    next_cycle();
    do_assign("R1 after redirect", 1'b1, 1'b1, 32'h104, 32'd3);

    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule